// File: doc/BRIEF.md
# Adaptive Phase Switch Decision Unit

This unit sits beside the light sequencer of a two-arm intersection and decides when the current phase should end. It keeps a queued-car count for each arm. A count rises on a pulse from that arm's entry sensor and falls on a pulse from its exit sensor. The unit runs a phase timer that counts clock cycles since the last switch. From the timer, the counts, the current phase and the favoured arm, it raises a one-cycle switch request. The sequencer acts on that request and reports the new phase back.

In a straight-through phase, the decision has three bands. Before the favoured arm's minimum duration, nothing can end the phase. At its maximum duration, the phase is always ended. Between the two, the phase ends when the favoured arm's queue is empty, or when a linear demand score drops to zero or below. The score is `trunc((alpha*n_own + beta) / 16) - n_other`. Here `alpha` and `beta` are signed fixed-point values with four fractional bits, and the division truncates toward zero. A left-turn phase has its own minimum and maximum. It also ends early once the favoured arm's count has been unchanged for a set number of cycles. A pedestrian phase ends once its timer reaches the programmed duration. After reset, the unit stays idle until a queue count changes for the first time.

Top module: `phase_switch_unit`

## Requirements
- R1: An entry pulse alone raises the arm's count by one in the next cycle. An exit pulse alone lowers it by one. Both pulses in the same cycle leave the count unchanged.
- R2: With the default 8-bit count, an arm's count saturates at 0 and at 255 and never wraps.
- R3: After reset, `switch_o` stays 0 and the timer does not run until one of the queue counts has changed.
- R4: Phase code 2'b00 is straight-through, and 2'b11 behaves the same way. In that phase, no switch is issued while the timer is below the favoured arm's minimum. `fav_i` = 0 selects arm 1 and `fav_i` = 1 selects arm 2.
- R5: In a straight-through phase, a switch is forced once the timer reaches the favoured arm's maximum, whatever the counts are.
- R6: In a straight-through phase, between minimum and maximum, a switch is issued when the favoured arm's count is zero.
- R7: In a straight-through phase, between minimum and maximum, a switch is issued when `trunc((alpha*n_own + beta)/16) - n_other <= 0`. Here `alpha` and `beta` are the favoured arm's 8-bit two's-complement coefficients, and the truncation is toward zero.
- R8: In the left-turn phase (code 2'b01), the left-turn minimum blocks a switch and the left-turn maximum forces one. The straight-through limits and the demand score are not used.
- R9: In the left-turn phase, between the left-turn limits, a switch is issued once the favoured arm's count has been unchanged for 5 cycles.
- R10: In the pedestrian phase (code 2'b10), a switch is issued once the timer reaches the pedestrian duration, and never before.
- R11: `switch_o` is high for exactly one cycle. The timer restarts from zero in the cycle the request is high, so each decision counts cycles from the previous request.
- R12: During and right after reset, both counts are 0 and `switch_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm1_in_i | input | 1 | Arm 1 entry sensor pulse |
| arm1_out_i | input | 1 | Arm 1 exit sensor pulse |
| arm2_in_i | input | 1 | Arm 2 entry sensor pulse |
| arm2_out_i | input | 1 | Arm 2 exit sensor pulse |
| phase_i | input | 2 | Current phase: 00 straight, 01 left turn, 10 pedestrian, 11 as straight |
| fav_i | input | 1 | Favoured arm: 0 arm 1, 1 arm 2 |
| alpha1_i | input | COEF_W | Arm 1 slope, signed, 4 fractional bits |
| beta1_i | input | COEF_W | Arm 1 offset, signed, 4 fractional bits |
| alpha2_i | input | COEF_W | Arm 2 slope, signed, 4 fractional bits |
| beta2_i | input | COEF_W | Arm 2 offset, signed, 4 fractional bits |
| min1_i | input | TIME_W | Arm 1 minimum straight-through duration |
| max1_i | input | TIME_W | Arm 1 maximum straight-through duration |
| min2_i | input | TIME_W | Arm 2 minimum straight-through duration |
| max2_i | input | TIME_W | Arm 2 maximum straight-through duration |
| left_min_i | input | TIME_W | Left-turn minimum duration |
| left_max_i | input | TIME_W | Left-turn maximum duration |
| ped_dur_i | input | TIME_W | Pedestrian duration |
| switch_o | output | 1 | One-cycle switch request |
| queue1_o | output | CNT_W | Arm 1 queued-car count |
| queue2_o | output | CNT_W | Arm 2 queued-car count |

## Verification
The assertions assume that the phase code, the favoured arm and the duration limits come from the sequencer and stay valid in the cycle before a request. The minimum checks compare against the values those inputs had in the deciding cycle. The stimulus changes phase, favoured arm and limits only between scenarios. These changes happen at the falling clock edge, so each deciding cycle sees one consistent set of values. Sensor pulses are single-cycle and include simultaneous entry and exit on one arm. They also push the counts past both of their limits, which exercises the one-step-per-cycle count property.

// File: rtl/pss_pkg.sv
package pss_pkg;

    typedef enum logic [1:0] {
        PH_STRAIGHT = 2'b00,
        PH_LEFT     = 2'b01,
        PH_PED      = 2'b10,
        PH_SPARE    = 2'b11
    } phase_e;

endpackage

// File: rtl/queue_counter.sv
module queue_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ent_i,
    input  logic             ext_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             chg_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ent_i && !ext_i && (st_q.cnt != '1)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (ext_i && !ent_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign chg_o = (st_d.cnt != st_q.cnt);

endmodule

// File: rtl/demand_eval.sv
module demand_eval #(
    parameter int CNT_W  = 8,
    parameter int COEF_W = 8,
    parameter int FRAC_W = 4
) (
    input  logic [COEF_W-1:0] alpha_i,
    input  logic [COEF_W-1:0] beta_i,
    input  logic [CNT_W-1:0]  own_cnt_i,
    input  logic [CNT_W-1:0]  other_cnt_i,
    output logic              le_zero_o
);

    localparam int PW = COEF_W + CNT_W + 3;

    logic signed [PW-1:0] a_x, b_x, n_x, o_x;
    logic signed [PW-1:0] prod, sum, quo, score;

    always_comb begin
        a_x  = PW'($signed(alpha_i));
        b_x  = PW'($signed(beta_i));
        n_x  = PW'($signed({1'b0, own_cnt_i}));
        o_x  = PW'($signed({1'b0, other_cnt_i}));
        prod = a_x * n_x;
        sum  = prod + b_x;
        // truncate toward zero: bias negative values before the shift
        if (sum[PW-1]) begin
            quo = (sum + PW'((1 << FRAC_W) - 1)) >>> FRAC_W;
        end else begin
            quo = sum >>> FRAC_W;
        end
        score     = quo - o_x;
        le_zero_o = score[PW-1] || (score == '0);
    end

endmodule

// File: rtl/phase_decider.sv
module phase_decider #(
    parameter int CNT_W     = 8,
    parameter int TIME_W    = 10,
    parameter int STALL_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        phase_i,
    input  logic              fav_i,
    input  logic [1:0]        chg_i,
    input  logic [1:0]        le_i,
    input  logic [CNT_W-1:0]  cnt1_i,
    input  logic [CNT_W-1:0]  cnt2_i,
    input  logic [TIME_W-1:0] min1_i,
    input  logic [TIME_W-1:0] max1_i,
    input  logic [TIME_W-1:0] min2_i,
    input  logic [TIME_W-1:0] max2_i,
    input  logic [TIME_W-1:0] left_min_i,
    input  logic [TIME_W-1:0] left_max_i,
    input  logic [TIME_W-1:0] ped_dur_i,
    output logic              switch_o
);

    import pss_pkg::*;

    localparam int STALL_W = $clog2(STALL_CYC + 1);

    typedef struct packed {
        logic               armed;
        logic               sw;
        logic [TIME_W-1:0]  t;
        logic [STALL_W-1:0] stall;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    phase_e            ph;
    logic              want;
    logic              fav_zero;
    logic              fav_le;
    logic              fav_chg;
    logic [TIME_W-1:0] lo, hi;

    always_comb begin
        ph       = phase_e'(phase_i);
        fav_zero = fav_i ? (cnt2_i == '0) : (cnt1_i == '0);
        fav_le   = fav_i ? le_i[1] : le_i[0];
        fav_chg  = fav_i ? chg_i[1] : chg_i[0];
        lo       = fav_i ? min2_i : min1_i;
        hi       = fav_i ? max2_i : max1_i;

        unique case (ph)
            PH_PED: begin
                want = (st_q.t >= ped_dur_i);
            end
            PH_LEFT: begin
                if (st_q.t < left_min_i) begin
                    want = 1'b0;
                end else if (st_q.t >= left_max_i) begin
                    want = 1'b1;
                end else begin
                    want = (st_q.stall >= STALL_W'(STALL_CYC));
                end
            end
            default: begin
                if (st_q.t < lo) begin
                    want = 1'b0;
                end else if (st_q.t >= hi) begin
                    want = 1'b1;
                end else begin
                    want = fav_zero || fav_le;
                end
            end
        endcase

        st_d       = st_q;
        st_d.sw    = st_q.armed && want && !st_q.sw;
        st_d.armed = st_q.armed || (|chg_i);

        if (st_d.sw || !st_q.armed) begin
            st_d.t = '0;
        end else if (st_q.t != '1) begin
            st_d.t = st_q.t + 1'b1;
        end

        if (st_d.sw || fav_chg) begin
            st_d.stall = '0;
        end else if (st_q.stall != '1) begin
            st_d.stall = st_q.stall + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign switch_o = st_q.sw;

endmodule

// File: rtl/phase_switch_unit.sv
module phase_switch_unit #(
    parameter int CNT_W     = 8,
    parameter int TIME_W    = 10,
    parameter int COEF_W    = 8,
    parameter int FRAC_W    = 4,
    parameter int STALL_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm1_in_i,
    input  logic              arm1_out_i,
    input  logic              arm2_in_i,
    input  logic              arm2_out_i,
    input  logic [1:0]        phase_i,
    input  logic              fav_i,
    input  logic [COEF_W-1:0] alpha1_i,
    input  logic [COEF_W-1:0] beta1_i,
    input  logic [COEF_W-1:0] alpha2_i,
    input  logic [COEF_W-1:0] beta2_i,
    input  logic [TIME_W-1:0] min1_i,
    input  logic [TIME_W-1:0] max1_i,
    input  logic [TIME_W-1:0] min2_i,
    input  logic [TIME_W-1:0] max2_i,
    input  logic [TIME_W-1:0] left_min_i,
    input  logic [TIME_W-1:0] left_max_i,
    input  logic [TIME_W-1:0] ped_dur_i,
    output logic              switch_o,
    output logic [CNT_W-1:0]  queue1_o,
    output logic [CNT_W-1:0]  queue2_o
);

    localparam int N_ARM = 2;

    logic [N_ARM-1:0]  ent_w, ext_w, chg_w, le_w;
    logic [CNT_W-1:0]  cnt_w   [N_ARM];
    logic [COEF_W-1:0] alpha_w [N_ARM];
    logic [COEF_W-1:0] beta_w  [N_ARM];

    assign ent_w      = {arm2_in_i, arm1_in_i};
    assign ext_w      = {arm2_out_i, arm1_out_i};
    assign alpha_w[0] = alpha1_i;
    assign alpha_w[1] = alpha2_i;
    assign beta_w[0]  = beta1_i;
    assign beta_w[1]  = beta2_i;

    for (genvar a = 0; a < N_ARM; a++) begin : g_arm
        queue_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .ent_i (ent_w[a]),
            .ext_i (ext_w[a]),
            .cnt_o (cnt_w[a]),
            .chg_o (chg_w[a])
        );

        demand_eval #(
            .CNT_W  (CNT_W),
            .COEF_W (COEF_W),
            .FRAC_W (FRAC_W)
        ) u_dem (
            .alpha_i     (alpha_w[a]),
            .beta_i      (beta_w[a]),
            .own_cnt_i   (cnt_w[a]),
            .other_cnt_i (cnt_w[N_ARM-1-a]),
            .le_zero_o   (le_w[a])
        );
    end

    phase_decider #(
        .CNT_W     (CNT_W),
        .TIME_W    (TIME_W),
        .STALL_CYC (STALL_CYC)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase_i),
        .fav_i      (fav_i),
        .chg_i      (chg_w),
        .le_i       (le_w),
        .cnt1_i     (cnt_w[0]),
        .cnt2_i     (cnt_w[1]),
        .min1_i     (min1_i),
        .max1_i     (max1_i),
        .min2_i     (min2_i),
        .max2_i     (max2_i),
        .left_min_i (left_min_i),
        .left_max_i (left_max_i),
        .ped_dur_i  (ped_dur_i),
        .switch_o   (switch_o)
    );

    assign queue1_o = cnt_w[0];
    assign queue2_o = cnt_w[1];

endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
    parameter int CNT_W  = 8,
    parameter int TIME_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phase_i,
    input logic              fav_i,
    input logic [TIME_W-1:0] min1_i,
    input logic [TIME_W-1:0] min2_i,
    input logic [TIME_W-1:0] ped_dur_i,
    input logic              switch_o,
    input logic [CNT_W-1:0]  queue1_o,
    input logic [CNT_W-1:0]  queue2_o
);

    logic [CNT_W-1:0]  q1_prev, q2_prev;
    logic              seen_q;
    logic [TIME_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1_prev <= '0;
            q2_prev <= '0;
            seen_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            q1_prev <= queue1_o;
            q2_prev <= queue2_o;
            seen_q  <= seen_q || (queue1_o != q1_prev) || (queue2_o != q2_prev);
            if (switch_o) begin
                gap_q <= '0;
            end else if (seen_q && (gap_q != '1)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    AST_SW_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        switch_o |=> !switch_o); // R11

    AST_Q1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (queue1_o == $past(queue1_o)) || (queue1_o == $past(queue1_o) + 1'b1)
        || (queue1_o == $past(queue1_o) - 1'b1)); // R1

    AST_Q2_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (queue2_o == $past(queue2_o)) || (queue2_o == $past(queue2_o) + 1'b1)
        || (queue2_o == $past(queue2_o) - 1'b1)); // R1

    AST_IDLE_UNTIL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !switch_o); // R3

    AST_MIN_ARM1: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_o && ($past(phase_i) == 2'b00) && !$past(fav_i))
        |-> (gap_q >= $past(min1_i))); // R4

    AST_MIN_ARM2: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_o && ($past(phase_i) == 2'b00) && $past(fav_i))
        |-> (gap_q >= $past(min2_i))); // R4

    AST_PED_DURATION: assert property (@(posedge clk) disable iff (!rst_n)
        (switch_o && ($past(phase_i) == 2'b10))
        |-> (gap_q >= $past(ped_dur_i))); // R10

endmodule

bind phase_switch_unit pss_checker #(
    .CNT_W  (CNT_W),
    .TIME_W (TIME_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_i   (phase_i),
    .fav_i     (fav_i),
    .min1_i    (min1_i),
    .min2_i    (min2_i),
    .ped_dur_i (ped_dur_i),
    .switch_o  (switch_o),
    .queue1_o  (queue1_o),
    .queue2_o  (queue2_o)
);

// File: tb/phase_switch_unit_bench.sv
`timescale 1ns/1ps
module phase_switch_unit_bench;

    localparam int CNT_W  = 8;
    localparam int TIME_W = 10;
    localparam int COEF_W = 8;
    localparam int CMAX   = 255;
    localparam int TMAX   = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic e1 = 0, x1 = 0, e2 = 0, x2 = 0;
    logic [1:0] phase = 2'b00;
    logic fav = 1'b0;
    logic signed [COEF_W-1:0] a1 = 8'sd16, b1 = 8'sd16, a2 = 8'sd16, b2 = 8'sd16;
    logic [TIME_W-1:0] mn1 = 0, mx1 = 3, mn2 = 3, mx2 = 15;
    logic [TIME_W-1:0] lmn = 3, lmx = 12, ped = 7;
    logic sw;
    logic [CNT_W-1:0] q1, q2;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R12";
    bit checking = 0;

    always #4 clk = ~clk;

    phase_switch_unit u_phase_switch_unit (
        .clk(clk), .rst_n(rst_n),
        .arm1_in_i(e1), .arm1_out_i(x1), .arm2_in_i(e2), .arm2_out_i(x2),
        .phase_i(phase), .fav_i(fav),
        .alpha1_i(a1), .beta1_i(b1), .alpha2_i(a2), .beta2_i(b2),
        .min1_i(mn1), .max1_i(mx1), .min2_i(mn2), .max2_i(mx2),
        .left_min_i(lmn), .left_max_i(lmx), .ped_dur_i(ped),
        .switch_o(sw), .queue1_o(q1), .queue2_o(q2)
    );

    // reference model state
    int m_n1, m_n2, m_t, m_stall, m_sw, m_armed;

    function automatic int score(input int al, input int be, input int own, input int oth);
        return (al * own + be) / 16 - oth;
    endfunction

    function automatic int step_cnt(input int n, input logic e, input logic x);
        if (e && !x && n < CMAX) return n + 1;
        if (x && !e && n > 0)    return n - 1;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n1 = 0; m_n2 = 0; m_t = 0; m_stall = 0; m_sw = 0; m_armed = 0;
        end else begin
            int nn1, nn2, nf_old, nf_new, lo, hi, sc;
            bit want, nsw;
            nn1 = step_cnt(m_n1, e1, x1);
            nn2 = step_cnt(m_n2, e2, x2);
            nf_old = fav ? m_n2 : m_n1;
            nf_new = fav ? nn2 : nn1;
            if (phase == 2'b10) begin
                want = (m_t >= int'(ped));
            end else if (phase == 2'b01) begin
                if (m_t < int'(lmn))       want = 0;
                else if (m_t >= int'(lmx)) want = 1;
                else                       want = (m_stall >= 5);
            end else begin
                lo = fav ? int'(mn2) : int'(mn1);
                hi = fav ? int'(mx2) : int'(mx1);
                sc = fav ? score(int'(a2), int'(b2), m_n2, m_n1)
                         : score(int'(a1), int'(b1), m_n1, m_n2);
                if (m_t < lo)       want = 0;
                else if (m_t >= hi) want = 1;
                else                want = (nf_old == 0) || (sc <= 0);
            end
            nsw = (m_armed != 0) && want && (m_sw == 0);
            if (nsw || m_armed == 0) m_t = 0;
            else if (m_t < TMAX)     m_t = m_t + 1;
            if (nsw || nf_new != nf_old) m_stall = 0;
            else if (m_stall < 7)        m_stall = m_stall + 1;
            if (nn1 != m_n1 || nn2 != m_n2) m_armed = 1;
            m_sw = nsw;
            m_n1 = nn1;
            m_n2 = nn2;
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            n_tests++;
            if (int'(sw) != m_sw || int'(q1) != m_n1 || int'(q2) != m_n2) begin
                n_fail++;
                $display("FAIL %s: sw=%0d q1=%0d q2=%0d expected sw=%0d q1=%0d q2=%0d",
                         cur_req, sw, q1, q2, m_sw, m_n1, m_n2);
            end
        end
    end

    task automatic pulse(input logic pe1, input logic px1, input logic pe2, input logic px2);
        @(negedge clk);
        #1;
        e1 = pe1; x1 = px1; e2 = pe2; x2 = px2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) pulse(0, 0, 0, 0);
    endtask

    // counts switch pulses over a window, checking them against the model
    task automatic count_sw(input int n, input int expect_min, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            pulse(0, 0, 0, 0);
            @(posedge clk); #1;
            if (sw) seen++;
        end
        n_tests++;
        if (seen < expect_min) begin
            n_fail++;
            $display("FAIL %s: switch pulses %0d expected at least %0d", req, seen, expect_min);
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (sw !== 1'b0 || q1 !== '0 || q2 !== '0) begin
            n_fail++;
            $display("FAIL R12: sw=%0d q1=%0d q2=%0d expected 0 0 0", sw, q1, q2);
        end
        @(negedge clk);
        rst_n = 1'b1;
        checking = 1;

        // R12 first cycles out of reset, R3 hold with limits that would otherwise switch
        idle(2);
        cur_req = "R3";
        idle(12);

        // R1 increments, decrements, simultaneous pulses
        cur_req = "R1";
        mn1 = 4; mx1 = 40;
        pulse(1, 0, 0, 0); pulse(1, 0, 0, 0); pulse(1, 0, 1, 0);
        pulse(0, 0, 1, 0); pulse(1, 1, 0, 0); pulse(0, 0, 1, 1);
        pulse(0, 0, 0, 1); pulse(1, 1, 1, 1);
        idle(2);

        // R7 truncation: alpha 0.5, beta 0, n1=3 n2=1 -> trunc(1.5)-1 = 0
        cur_req = "R7";
        a1 = 8'sd8; b1 = 8'sd0;
        count_sw(30, 3, "R7");
        a1 = -8'sd24; b1 = 8'sd16;
        idle(20);

        // R5 large demand: only the maximum ends the phase
        cur_req = "R5";
        a1 = 8'sd64; b1 = 8'sd64; mx1 = 12;
        count_sw(40, 2, "R5");

        // R4 minimum blocks even with an empty favoured queue
        cur_req = "R4";
        fav = 1'b1; mn2 = 6; mx2 = 50; a2 = 8'sd64; b2 = 8'sd64;
        pulse(0, 0, 0, 1);
        idle(30);

        // R6 zero count on favoured arm with positive score
        cur_req = "R6";
        mn2 = 3;
        count_sw(20, 2, "R6");

        // R2 saturation at both ends
        cur_req = "R2";
        fav = 1'b0; mx1 = 1000; mn1 = 1000;
        for (int i = 0; i < 4; i++) pulse(0, 0, 0, 1);
        for (int i = 0; i < 262; i++) pulse(1, 0, 0, 0);
        idle(2);
        for (int i = 0; i < 3; i++) pulse(0, 1, 0, 0);
        idle(2);

        // R8 left-turn maximum while counts keep moving
        cur_req = "R8";
        phase = 2'b01; lmn = 3; lmx = 12;
        for (int i = 0; i < 20; i++) begin
            pulse(1, 0, 0, 0);
            pulse(0, 1, 0, 0);
        end

        // R9 left-turn stall after five unchanged cycles
        cur_req = "R9";
        lmx = 200;
        count_sw(30, 3, "R9");

        // R10 pedestrian duration
        cur_req = "R10";
        phase = 2'b10; ped = 7;
        count_sw(30, 3, "R10");

        // R11 limits of zero: pulses must still be one cycle wide
        cur_req = "R11";
        phase = 2'b11; mn1 = 0; mx1 = 0;
        count_sw(12, 5, "R11");
        idle(3);

        checking = 0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule